// File: doc/BRIEF.md
# Chip Idle and Wake Controller

This block decides when a dual-processor chip may stop its clocks and when it must start them again. It gathers idle-ready indications from four clock domains (host processor, DSP, traffic controller, PLL) and the host's wait-for-interrupt signal. When every domain is quiet and the host is waiting, it enters either a light chip idle or a deep sleep. In light idle only the timer clock keeps running. In deep sleep every internal clock is stopped, and an external power/clock module is asked to switch the reference clock off.

Wake sources are per-source maskable interrupts, a DMA clock request and an interconnect enable line. A mode input selects how the block wakes. In direct mode, one wake condition restarts the clocks at once. In handshake mode, the external module brings the clock back and reports that it is stable.

The block also holds a memory self-refresh flag that clears itself on every exit from idle. A sticky record shows which wake source ended the last idle period. Software clears that record by writing ones.

Top module: `chip_idle_ctrl`

## Requirements
- R1: After reset the state is RUN (code 0), `ck_en` is all ones, `clk_off_req` is 0, `sr_en` is 0 and `wake_src` is 0.
- R2: In RUN, `host_wfi` with no wake condition moves to WAIT_DOMAINS (code 1). WAIT_DOMAINS goes back to RUN if `host_wfi` drops. It moves to IDLE (code 2) when `cfg_deep`=0, or to DEEP_SLEEP_REQ (code 3) when `cfg_deep`=1, only when host, DSP, traffic-controller and PLL idle conditions all hold together with `host_wfi`.
- R3: With `dsp_clk_en`=0 the DSP condition counts as met whatever `dsp_idle_rdy` is.
- R4: `ck_en` bit 0 is host, bit 1 DSP, bit 2 PLL, bit 3 reference-fed peripherals and bit 4 timers. It is all ones in RUN and WAIT_DOMAINS, 5'b10000 in IDLE, and zero in DEEP_SLEEP_REQ, DEEP_SLEEP and WAKE. It changes only on the clock edge where the state changes.
- R5: `clk_off_req` rises on entry to DEEP_SLEEP_REQ. It stays high, with the state held, until `clk_off_ack` arrives. The state then moves to DEEP_SLEEP (code 4), and the request stays high until the block leaves DEEP_SLEEP.
- R6: The wake condition is any `irq` bit whose `irq_mask` bit is 0, `dma_req`, or `ic_en`. An `irq` bit whose mask bit is 1 has no effect. A wake condition in WAIT_DOMAINS returns the block to RUN.
- R7: With `cfg_wake_direct`=1, a wake condition in IDLE moves to RUN in one cycle. With `cfg_wake_direct`=0 it moves to WAKE (code 5). From DEEP_SLEEP a wake condition always moves to WAKE.
- R8: In WAKE, `clk_off_req` is 0 and `ck_en` stays zero until `clk_stable` is seen. The block then returns to RUN with all clocks on.
- R9: `sr_set` sets `sr_en` and `sr_clr` clears it. Every exit from IDLE or DEEP_SLEEP clears it, and that clear wins over `sr_set`.
- R10: On each exit from IDLE or DEEP_SLEEP, the active causes are OR-ed into `wake_src`: bit 0 for an unmasked interrupt, bit 1 for DMA, bit 2 for the interconnect enable. Each bit stays set until a 1 is written to the same bit of `wake_src_clr`. A new record in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_idle_rdy | input | 1 | Host domain idle conditions met |
| dsp_idle_rdy | input | 1 | DSP reports idle |
| dsp_clk_en | input | 1 | DSP clock enable bit from software |
| tc_idle_rdy | input | 1 | Traffic controller idle conditions met |
| pll_idle_rdy | input | 1 | PLL idle conditions met |
| host_wfi | input | 1 | Host is in wait-for-interrupt |
| cfg_wake_direct | input | 1 | 1: direct wake, 0: handshaked wake |
| cfg_deep | input | 1 | 1: deep sleep, 0: light chip idle |
| irq | input | N_IRQ | Interrupt requests to either processor |
| irq_mask | input | N_IRQ | 1 masks the matching interrupt |
| dma_req | input | 1 | DMA clock request |
| ic_en | input | 1 | Interconnect enable wake line |
| clk_off_req | output | 1 | Request to external module to stop reference clock |
| clk_off_ack | input | 1 | External module acknowledges clock off |
| clk_stable | input | 1 | External module reports clock stable |
| sr_set | input | 1 | Software set of self-refresh flag |
| sr_clr | input | 1 | Software clear of self-refresh flag |
| sr_en | output | 1 | Memory self-refresh enable |
| wake_src_clr | input | 3 | Write-one-to-clear for wake_src |
| wake_src | output | 3 | Sticky record of last wake causes |
| state_o | output | 3 | Current controller state code |
| ck_en | output | 5 | Clock enables per domain |

## Verification
Every output is a register loaded from the next-state logic. A change in any input therefore shows on `state_o`, `ck_en`, `clk_off_req`, `sr_en` and `wake_src` exactly one clock edge later. The bench drives inputs a short delay after a rising edge and samples the outputs the same short delay after the following rising edge, so each result is read in the first cycle it is due. Multi-step behaviour, such as the held request before acknowledge and the WAKE wait for `clk_stable`, is checked at every intermediate cycle. This confirms that nothing moves early.

// File: rtl/chip_idle_ctrl.sv
module chip_idle_ctrl #(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_idle_rdy,
  input  logic             dsp_idle_rdy,
  input  logic             dsp_clk_en,
  input  logic             tc_idle_rdy,
  input  logic             pll_idle_rdy,
  input  logic             host_wfi,
  input  logic             cfg_wake_direct,
  input  logic             cfg_deep,
  input  logic [N_IRQ-1:0] irq,
  input  logic [N_IRQ-1:0] irq_mask,
  input  logic             dma_req,
  input  logic             ic_en,
  output logic             clk_off_req,
  input  logic             clk_off_ack,
  input  logic             clk_stable,
  input  logic             sr_set,
  input  logic             sr_clr,
  output logic             sr_en,
  input  logic [2:0]       wake_src_clr,
  output logic [2:0]       wake_src,
  output logic [2:0]       state_o,
  output logic [4:0]       ck_en
);

  localparam logic [2:0] S_RUN   = 3'd0;
  localparam logic [2:0] S_WAIT  = 3'd1;
  localparam logic [2:0] S_IDLE  = 3'd2;
  localparam logic [2:0] S_DSREQ = 3'd3;
  localparam logic [2:0] S_DEEP  = 3'd4;
  localparam logic [2:0] S_WAKE  = 3'd5;

  localparam logic [4:0] EN_ALL   = 5'b11111;
  localparam logic [4:0] EN_TIMER = 5'b10000;

  logic [2:0] st_q, st_d;
  logic [2:0] cause;
  logic       wake, all_idle, exiting;

  assign cause    = {ic_en, dma_req, |(irq & ~irq_mask)};
  assign wake     = |cause;
  assign all_idle = host_idle_rdy & (dsp_idle_rdy | ~dsp_clk_en) & tc_idle_rdy & pll_idle_rdy;
  assign exiting  = (st_q == S_IDLE || st_q == S_DEEP) && (st_d != st_q);
  assign state_o  = st_q;

  function automatic logic [4:0] enables(input logic [2:0] s);
    case (s)
      S_RUN, S_WAIT: enables = EN_ALL;
      S_IDLE:        enables = EN_TIMER;
      default:       enables = '0;
    endcase
  endfunction

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_RUN:   if (host_wfi && !wake) st_d = S_WAIT;
      S_WAIT:  if (wake || !host_wfi) st_d = S_RUN;
               else if (all_idle)     st_d = cfg_deep ? S_DSREQ : S_IDLE;
      S_IDLE:  if (wake) st_d = cfg_wake_direct ? S_RUN : S_WAKE;
      S_DSREQ: if (clk_off_ack) st_d = S_DEEP;
      S_DEEP:  if (wake) st_d = S_WAKE;
      S_WAKE:  if (clk_stable) st_d = S_RUN;
      default: st_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_RUN;
      ck_en       <= EN_ALL;
      clk_off_req <= 1'b0;
      sr_en       <= 1'b0;
      wake_src    <= '0;
    end else begin
      st_q        <= st_d;
      ck_en       <= enables(st_d);
      clk_off_req <= (st_d == S_DSREQ) || (st_d == S_DEEP);
      if (exiting)     sr_en <= 1'b0;
      else if (sr_clr) sr_en <= 1'b0;
      else if (sr_set) sr_en <= 1'b1;
      wake_src    <= (wake_src & ~wake_src_clr) | (exiting ? cause : 3'b000);
    end
  end

  assert_idle_needs_domains_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && $past(st_q) == S_WAIT) |-> $past(all_idle && host_wfi));

  assert_clocks_move_with_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ck_en) |-> (st_q != $past(st_q)));

  assert_req_held_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_off_req && !clk_off_ack && st_q == S_DSREQ) |=> clk_off_req);

  assert_masked_irq_no_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && !dma_req && !ic_en && ((irq & ~irq_mask) == '0)) |=> st_q == S_IDLE);

  assert_wake_waits_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAKE && !clk_stable) |=> (ck_en == '0 && !clk_off_req));

  assert_sr_cleared_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st_q) == S_IDLE || $past(st_q) == S_DEEP) && st_q != $past(st_q)) |-> !sr_en);

endmodule

// File: tb/tb_chip_idle_ctrl.sv
`timescale 1ns/100ps
module tb_chip_idle_ctrl;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic host_idle_rdy, dsp_idle_rdy, dsp_clk_en, tc_idle_rdy, pll_idle_rdy, host_wfi;
  logic cfg_wake_direct, cfg_deep;
  logic [N-1:0] irq, irq_mask;
  logic dma_req, ic_en, clk_off_req, clk_off_ack, clk_stable;
  logic sr_set, sr_clr, sr_en;
  logic [2:0] wake_src_clr, wake_src, state_o;
  logic [4:0] ck_en;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  chip_idle_ctrl #(.N_IRQ(N)) dut (
    .clk(clk), .rst_n(rst_n),
    .host_idle_rdy(host_idle_rdy), .dsp_idle_rdy(dsp_idle_rdy), .dsp_clk_en(dsp_clk_en),
    .tc_idle_rdy(tc_idle_rdy), .pll_idle_rdy(pll_idle_rdy), .host_wfi(host_wfi),
    .cfg_wake_direct(cfg_wake_direct), .cfg_deep(cfg_deep),
    .irq(irq), .irq_mask(irq_mask), .dma_req(dma_req), .ic_en(ic_en),
    .clk_off_req(clk_off_req), .clk_off_ack(clk_off_ack), .clk_stable(clk_stable),
    .sr_set(sr_set), .sr_clr(sr_clr), .sr_en(sr_en),
    .wake_src_clr(wake_src_clr), .wake_src(wake_src),
    .state_o(state_o), .ck_en(ck_en)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    host_idle_rdy = 0; dsp_idle_rdy = 0; dsp_clk_en = 1; tc_idle_rdy = 0; pll_idle_rdy = 0;
    host_wfi = 0; cfg_wake_direct = 0; cfg_deep = 0; irq = '0; irq_mask = '0;
    dma_req = 0; ic_en = 0; clk_off_ack = 0; clk_stable = 0;
    sr_set = 0; sr_clr = 0; wake_src_clr = '0;
    tick; tick;
    rst_n = 1'b1;
    tick;
  endtask

  task automatic enter_idle(input bit deep);
    host_idle_rdy = 1; dsp_idle_rdy = 1; tc_idle_rdy = 1; pll_idle_rdy = 1;
    cfg_deep = deep;
    host_wfi = 1;
    tick;
    tick;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 act=timeout exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset;
    chk("R1 state", state_o, 0);
    chk("R1 ck_en", ck_en, 31);
    chk("R1 req", clk_off_req, 0);
    chk("R1 sr", sr_en, 0);
    chk("R1 wake_src", wake_src, 0);

    // R2 R3: sweep of all domain-ready combinations
    for (int v = 0; v < 32; v++) begin
      int all;
      do_reset;
      host_wfi = 1;
      tick;
      chk("R2 run->wait", state_o, 1);
      host_idle_rdy = v[0]; dsp_idle_rdy = v[1]; tc_idle_rdy = v[2];
      pll_idle_rdy = v[3]; dsp_clk_en = v[4];
      tick;
      all = v[0] & (v[1] | ~v[4]) & v[2] & v[3];
      chk("R2_R3 wait->idle", state_o, all ? 2 : 1);
      chk("R4 idle clocks", ck_en, all ? 16 : 31);
    end

    // R2: dropping wfi in WAIT returns to RUN
    do_reset;
    host_wfi = 1; tick;
    host_wfi = 0; tick;
    chk("R2 wfi drop", state_o, 0);

    // R6: wake in WAIT aborts
    do_reset;
    host_wfi = 1; tick;
    dma_req = 1; tick;
    chk("R6 wait abort", state_o, 0);
    chk("R6 wait abort ck", ck_en, 31);

    // R6 R7 R10: sweep of interrupts, masks and wake mode
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 16; i++) begin
        for (int k = 0; k < 16; k++) begin
          int un;
          do_reset;
          cfg_wake_direct = m[0];
          enter_idle(0);
          irq = i[N-1:0]; irq_mask = k[N-1:0];
          tick;
          un = i & ~k & 15;
          if (un != 0) begin
            chk("R7 wake state", state_o, m ? 0 : 5);
            chk("R7 wake ck", ck_en, m ? 31 : 0);
            chk("R10 irq record", wake_src, 1);
          end else begin
            chk("R6 masked stays", state_o, 2);
            chk("R6 masked ck", ck_en, 16);
            chk("R10 no record", wake_src, 0);
          end
        end
      end
    end

    // R5 R8 R10: deep sleep handshake
    do_reset;
    enter_idle(1);
    chk("R5 dsreq", state_o, 3);
    chk("R5 req", clk_off_req, 1);
    chk("R4 dsreq ck", ck_en, 0);
    irq = 4'b0001;
    for (int c = 0; c < 3; c++) begin
      tick;
      chk("R5 hold state", state_o, 3);
      chk("R5 hold req", clk_off_req, 1);
    end
    irq = '0;
    clk_off_ack = 1; tick;
    chk("R5 deep", state_o, 4);
    chk("R5 deep req", clk_off_req, 1);
    clk_off_ack = 0; tick;
    chk("R5 deep holds", state_o, 4);
    chk("R5 deep req holds", clk_off_req, 1);
    dma_req = 1; tick;
    dma_req = 0;
    chk("R7 deep->wake", state_o, 5);
    chk("R8 wake req", clk_off_req, 0);
    chk("R8 wake ck", ck_en, 0);
    chk("R10 dma record", wake_src, 2);
    tick; tick;
    chk("R8 wait stable", state_o, 5);
    chk("R8 wait stable ck", ck_en, 0);
    clk_stable = 1; tick;
    chk("R8 run", state_o, 0);
    chk("R8 run ck", ck_en, 31);
    host_wfi = 0;
    wake_src_clr = 3'b010; tick; wake_src_clr = '0;
    chk("R10 w1c", wake_src, 0);

    // R7: direct mode from deep still goes through WAKE, ic_en record
    do_reset;
    cfg_wake_direct = 1;
    enter_idle(1);
    clk_off_ack = 1; tick; clk_off_ack = 0;
    ic_en = 1; wake_src_clr = 3'b100; tick;
    ic_en = 0; wake_src_clr = '0;
    chk("R7 direct deep->wake", state_o, 5);
    chk("R10 set beats clear", wake_src, 4);

    // R9: self-refresh flag
    do_reset;
    sr_set = 1; tick; sr_set = 0;
    chk("R9 set", sr_en, 1);
    sr_clr = 1; tick; sr_clr = 0;
    chk("R9 clr", sr_en, 0);
    sr_set = 1; tick; sr_set = 0;
    enter_idle(0);
    chk("R9 kept in idle", sr_en, 1);
    irq = 4'b0100; tick; irq = '0;
    chk("R9 cleared on exit", sr_en, 0);
    do_reset;
    cfg_wake_direct = 1;
    sr_set = 1; tick;
    enter_idle(0);
    chk("R9 set in idle", sr_en, 1);
    ic_en = 1; tick;
    ic_en = 0; sr_set = 0;
    chk("R9 exit beats set", sr_en, 0);
    chk("R7 direct idle->run", state_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule